// File: doc/BRIEF.md
# Flow-Through Memory Address Register with Early Load and Read Start

This block holds the memory address of a microcoded processor and starts memory reads from it. The address has two load paths. The first is the ordinary functional-destination write, which carries the ALU result. The second is an early load, which takes the right-hand source operand directly, one pipeline stage before that instruction's destination write would happen. Both paths are flow-through. A value presented on either path reaches the memory address output in the same cycle, so memory can begin its access at once. The value seen by the functional source (readback) path trails the load by two cycles.

A read request is a one-cycle pulse. It is raised when a start-read is issued while no memory cycle is in progress. If the type checker flags a datatype error in the cycle of the start, the request is withheld. Any address load in that cycle still happens, so an early start-read with a type error becomes a plain early address load.

The block also keeps the source lock on the address and data registers. For a late start, the lock waits for the memory-output-begin strobe. For an early start, the lock is in place from the next cycle. The lock is released by the memory-done strobe. Address writes are always accepted, including while a cycle is pending or locked.

Top module: `mar_early_unit`

## Requirements
- R1: After synchronous reset, with all inputs low, mem_addr and rdback are 0, rd_req is 0 and lock is 0.
- R2: When wr_en is 1 and early_ld is 0, mem_addr equals wr_data in that same cycle, and that value is held on mem_addr in later cycles that have no load.
- R3: When early_ld is 1, mem_addr equals rsrc_data in that same cycle. This holds whether or not wr_en is also 1, because the early path has priority.
- R4: A value loaded in cycle t appears on rdback from cycle t+2. In cycle t+1, rdback still shows the value that was held before the load.
- R5: rd_req is 1 in exactly the cycle in which start_rd is 1, type_err is 0 and no memory cycle is pending or locked. It is never 1 in two consecutive cycles.
- R6: start_rd with type_err at 1 gives rd_req 0, starts no memory cycle (lock stays 0 and a later start is still honoured), and the address load of that cycle still takes effect.
- R7: After a late start (early_flag 0), lock stays 0 until mfo_begin is seen, and becomes 1 in the cycle after mfo_begin.
- R8: After an early start (early_flag 1), lock is 1 from the next cycle.
- R9: While lock is 1, a mem_done pulse makes lock 0 in the next cycle. mem_done while a late cycle still waits for mfo_begin has no effect.
- R10: start_rd while a memory cycle is pending or locked is ignored: rd_req stays 0 and the lock state is unchanged.
- R11: Address writes and early loads issued while a cycle is pending or locked update mem_addr exactly as in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | AW | Functional-destination write data |
| wr_en | input | 1 | Functional-destination write enable |
| rsrc_data | input | AW | Right-hand source operand for early load |
| early_ld | input | 1 | Early address load enable |
| start_rd | input | 1 | Start a memory read |
| early_flag | input | 1 | Marks the start as an early start |
| type_err | input | 1 | Datatype error for the current start |
| mfo_begin | input | 1 | Memory output phase begins |
| mem_done | input | 1 | Memory cycle complete |
| mem_addr | output | AW | Address to memory, flow-through |
| rd_req | output | 1 | One-cycle memory read request |
| rdback | output | AW | Address as seen by the functional source path |
| lock | output | 1 | Source lock on address and data registers |

## Verification
The assertions assume that reset is held for at least one clock edge before operation. The readback-lag property is armed only once two edges have passed since reset. They also assume that mfo_begin and mem_done are meaningful only in the controller state the requirements give them, and that the design ignores them otherwise. The stimulus sweeps every combination of the five control inputs from the idle state over several address patterns. After each combination it drives mfo_begin and then mem_done, so that every sweep step starts idle again. A directed sequence issues loads and repeated starts while a cycle is pending and while it is locked.

// File: rtl/mar_pkg.sv
package mar_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE     = 2'd0,
        CYC_WAIT_OUT = 2'd1,
        CYC_LOCKED   = 2'd2
    } cyc_state_e;

    typedef struct packed {
        logic start;
        logic early;
        logic type_err;
        logic out_begin;
        logic done;
    } cyc_ctl_s;

    typedef enum logic [1:0] {
        SEL_HOLD  = 2'd0,
        SEL_WRITE = 2'd1,
        SEL_EARLY = 2'd2
    } addr_sel_e;

    function automatic addr_sel_e pick_source(input logic early_ld, input logic wr_en);
        if (early_ld)   return SEL_EARLY;
        else if (wr_en) return SEL_WRITE;
        else            return SEL_HOLD;
    endfunction

    function automatic logic read_granted(input cyc_state_e st, input cyc_ctl_s c);
        return (st == CYC_IDLE) && c.start && !c.type_err;
    endfunction

endpackage

// File: rtl/mar_addr_path.sv
module mar_addr_path
    import mar_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    input  logic          early_ld,
    input  logic [AW-1:0] rsrc_data,
    output logic [AW-1:0] addr_live,
    output logic [AW-1:0] addr_rb
);

    addr_sel_e     sel;
    logic [AW-1:0] held_q;
    logic [AW-1:0] rb_q;

    always_comb begin
        sel = pick_source(early_ld, wr_en);
        unique case (sel)
            SEL_EARLY: addr_live = rsrc_data;
            SEL_WRITE: addr_live = wr_data;
            default:   addr_live = held_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            rb_q   <= '0;
        end else begin
            held_q <= addr_live;
            rb_q   <= held_q;
        end
    end

    assign addr_rb = rb_q;

endmodule

// File: rtl/mar_cycle_ctl.sv
module mar_cycle_ctl
    import mar_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cyc_ctl_s ctl,
    output logic     rd_req,
    output logic     lock
);

    cyc_state_e st_q;
    cyc_state_e st_d;
    logic       grant;

    always_comb begin
        grant = read_granted(st_q, ctl);
        st_d  = st_q;
        unique case (st_q)
            CYC_IDLE: begin
                if (grant) st_d = ctl.early ? CYC_LOCKED : CYC_WAIT_OUT;
            end
            CYC_WAIT_OUT: begin
                if (ctl.out_begin) st_d = CYC_LOCKED;
            end
            CYC_LOCKED: begin
                if (ctl.done) st_d = CYC_IDLE;
            end
            default: st_d = CYC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= CYC_IDLE;
        else     st_q <= st_d;
    end

    assign rd_req = grant;
    assign lock   = (st_q == CYC_LOCKED);

endmodule

// File: rtl/mar_early_unit.sv
module mar_early_unit
    import mar_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] wr_data,
    input  logic          wr_en,
    input  logic [AW-1:0] rsrc_data,
    input  logic          early_ld,
    input  logic          start_rd,
    input  logic          early_flag,
    input  logic          type_err,
    input  logic          mfo_begin,
    input  logic          mem_done,
    output logic [AW-1:0] mem_addr,
    output logic          rd_req,
    output logic [AW-1:0] rdback,
    output logic          lock
);

    cyc_ctl_s ctl;

    always_comb begin
        ctl.start     = start_rd;
        ctl.early     = early_flag;
        ctl.type_err  = type_err;
        ctl.out_begin = mfo_begin;
        ctl.done      = mem_done;
    end

    mar_addr_path #(.AW(AW)) addr_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .early_ld  (early_ld),
        .rsrc_data (rsrc_data),
        .addr_live (mem_addr),
        .addr_rb   (rdback)
    );

    mar_cycle_ctl ctl_i (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .rd_req (rd_req),
        .lock   (lock)
    );

endmodule

// File: rtl/mar_early_unit_chk.sv
module mar_early_unit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] wr_data,
    input logic          wr_en,
    input logic [AW-1:0] rsrc_data,
    input logic          early_ld,
    input logic          start_rd,
    input logic          early_flag,
    input logic          type_err,
    input logic          mfo_begin,
    input logic          mem_done,
    input logic [AW-1:0] mem_addr,
    input logic          rd_req,
    input logic [AW-1:0] rdback,
    input logic          lock
);

    logic [1:0] seen;

    always_ff @(posedge clk) begin
        if (rst)              seen <= 2'd0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd0) |-> (!lock && rdback == '0)); // R1

    AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !early_ld) |-> (mem_addr == wr_data)); // R2

    AST_EARLY_THROUGH: assert property (@(posedge clk) disable iff (rst)
        early_ld |-> (mem_addr == rsrc_data)); // R3

    AST_READBACK_LAG: assert property (@(posedge clk) disable iff (rst)
        (seen >= 2'd2) |-> (rdback == $past(mem_addr, 2))); // R4

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req); // R5

    AST_REQ_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> start_rd); // R5

    AST_TYPE_ERR_CANCEL: assert property (@(posedge clk) disable iff (rst)
        type_err |-> !rd_req); // R6

    AST_LATE_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !early_flag) |=> !lock); // R7

    AST_EARLY_LOCK: assert property (@(posedge clk) disable iff (rst)
        (rd_req && early_flag) |=> lock); // R8

    AST_DONE_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        (lock && mem_done) |=> !lock); // R9

    AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        lock |-> !rd_req); // R10

endmodule

bind mar_early_unit mar_early_unit_chk #(.AW(AW)) chk_i (.*);

// File: tb/mar_early_unit_tb.sv
module mar_early_unit_tb_top;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] wr_data = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] rsrc_data = '0;
    logic          early_ld = 1'b0;
    logic          start_rd = 1'b0;
    logic          early_flag = 1'b0;
    logic          type_err = 1'b0;
    logic          mfo_begin = 1'b0;
    logic          mem_done = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          rd_req;
    logic [AW-1:0] rdback;
    logic          lock;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference state: held address, readback stage, cycle state (0 idle, 1 wait, 2 locked)
    logic [AW-1:0] m_addr = '0;
    logic [AW-1:0] m_rb   = '0;
    int            m_st   = 0;

    always #2 clk = ~clk;

    mar_early_unit #(.AW(AW)) dut_i (.*);

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, check just after, advance the model
    task automatic cyc(input logic we, input logic [AW-1:0] wd, input logic el,
                       input logic [AW-1:0] rs, input logic st, input logic ef,
                       input logic te, input logic mb, input logic md);
        logic [AW-1:0] e_addr;
        logic          e_req;
        string         a_tag;
        string         q_tag;
        string         l_tag;
        @(negedge clk);
        wr_en = we; wr_data = wd; early_ld = el; rsrc_data = rs;
        start_rd = st; early_flag = ef; type_err = te; mfo_begin = mb; mem_done = md;
        #1;
        e_addr = el ? rs : (we ? wd : m_addr);
        e_req  = (m_st == 0) && st && !te;
        a_tag  = (m_st != 0 && (we || el)) ? "R11" : (el ? "R3" : "R2");
        q_tag  = (m_st != 0 && st) ? "R10" : ((st && te) ? "R6" : "R5");
        l_tag  = (m_st == 2) ? "R8/R9" : "R7";
        check(a_tag, mem_addr, e_addr);
        check(q_tag, {{(AW-1){1'b0}}, rd_req}, {{(AW-1){1'b0}}, e_req});
        check(l_tag, {{(AW-1){1'b0}}, lock}, {{(AW-1){1'b0}}, (m_st == 2)});
        check("R4", rdback, m_rb);
        m_rb   = m_addr;
        m_addr = e_addr;
        case (m_st)
            0: if (e_req) m_st = ef ? 2 : 1;
            1: if (mb) m_st = 2;
            2: if (md) m_st = 0;
            default: m_st = 0;
        endcase
    endtask

    task automatic idle_cyc();
        cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        // R1: reset with a write pending on the inputs
        wr_en = 1'b1; wr_data = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0; wr_data = '0;
        #1;
        check("R1", mem_addr, '0);
        check("R1", rdback, '0);
        check("R1", {{(AW-1){1'b0}}, rd_req}, '0);
        check("R1", {{(AW-1){1'b0}}, lock}, '0);
        @(posedge clk);

        // sweep every control combination from idle over several address patterns
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 32; c++) begin
                logic [AW-1:0] pat;
                pat = (32'h0000_0001 << (p * 9)) ^ (32'h0101_0101 * (c + 1)) ^ (p * 32'h3C00_00A5);
                cyc(c[0], pat, c[1], ~pat, c[2], c[3], c[4], 1'b0, 1'b0);
                idle_cyc();
                // R9: done while only waiting has no effect, then output phase, then done
                cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, m_st == 1);
                cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
                cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
                idle_cyc();
            end
        end

        // directed: late start, loads and restarts while pending and locked (R7, R10, R11)
        cyc(1'b1, 32'h0000_1000, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 32'h0000_2000, 1'b0, '0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b1, 32'h0000_3000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        cyc(1'b1, 32'h0000_4000, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b1, 32'h0000_5000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        idle_cyc();
        // R6 then R8: cancelled early start, immediately followed by a good one
        cyc(1'b0, '0, 1'b1, 32'hAAAA_0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b1, 32'hBBBB_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        idle_cyc();
        cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        idle_cyc();
        idle_cyc();

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule